// File: doc/BRIEF.md
# Segmented Page-Map Address Translator

This block turns a 32-bit virtual address into a physical address by walking two on-chip lookup arrays. The first array, the segment map, is indexed by the current context number joined with a slice of the virtual address above the page bits, and it yields a page-group number. The second array, the page-entry store, is indexed by that group number joined with the six page-select bits of the address, and it yields a 32-bit page entry. The entry is checked for validity and access rights. On success the block sets the entry's used bit, and on a write its modified bit too, and stores the entry back. It then returns the physical frame joined with the 12-bit page offset. On failure it returns a fault code.

Requests arrive on a valid/ready handshake. `req_ready` is high whenever no translation is in flight. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The address, context and access flags need only be stable in that cycle. The result comes back as a one-cycle `rsp_valid` pulse on the following edge. The result side has no back-pressure, so the consumer must take the pulse when it appears. Both arrays are loaded through two plain write ports. A load is dropped if a translation is in flight, or if a request is being accepted in the same cycle.

With default parameters the arrays are smaller than a full configuration. The segment slice is `VSEG_W` bits starting at address bit 18, and the group number is `GRP_W` bits wide. A full configuration uses `VSEG_W`=12 and `GRP_W`=7.

Top module: `xlat_segpage`

## Requirements
- R1: A request whose address bits 31:29 are neither 000 nor 111 completes with `rsp_fault`=1 and `rsp_code`=0 (hole). In that case `rsp_paddr`, `rsp_nc`, `rsp_space` and `rsp_entry` are all zero, and neither array changes.
- R2: The segment-map index is {`req_ctx`, `req_va[18+VSEG_W-1:18]`}, with the context in the upper bits. The same address under two contexts therefore reaches two independent map entries.
- R3: The page-entry index is {group number, `req_va[17:12]`}. On success, `rsp_paddr` = {entry[15:0], `req_va[11:0]`}.
- R4: An entry whose bit 31 (valid) is 0 faults with code 1. Such a fault returns zero address, nc and space, and it returns the unmodified entry on `rsp_entry`.
- R5: A write (`req_write`=1) to an entry whose bit 30 (write allowed) is 0 faults with code 2.
- R6: A user-mode access (`req_user`=1) to an entry whose bit 29 (supervisor only) is 1 faults with code 3.
- R7: When several conditions apply, the lowest code wins: hole, then invalid, then write-protect, then privilege.
- R8: On success, entry bit 25 (used) is set, and on a write bit 24 (modified) is set too. The updated entry is stored back into the array and presented on `rsp_entry`.
- R9: On success, `rsp_nc` is entry bit 28 and `rsp_space` is entry bits 27:26.
- R10: `req_ready` is low only in the cycle after an acceptance. `rsp_valid` pulses for exactly one cycle on the edge after the accepting edge, so back-to-back requests are taken every second cycle. Success responses carry `rsp_code`=0.
- R11: A segment-map or page-entry load is ignored while a translation is in flight, and also in a cycle where `req_valid` is high with `req_ready` high.
- R12: After reset, `req_ready`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_va | input | 32 | Virtual address |
| req_ctx | input | CTX_W | Current context number |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| seg_wr_en | input | 1 | Load one segment-map entry |
| seg_wr_idx | input | CTX_W+VSEG_W | Segment-map entry to load |
| seg_wr_grp | input | GRP_W | Page-group number to store |
| pte_wr_en | input | 1 | Load one page entry |
| pte_wr_idx | input | GRP_W+6 | Page-entry slot to load |
| pte_wr_data | input | 32 | Page entry to store |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 2 | Fault code: 0 hole, 1 invalid, 2 write-protect, 3 privilege |
| rsp_paddr | output | FRAME_W+12 | Physical address |
| rsp_nc | output | 1 | Page is non-cacheable |
| rsp_space | output | 2 | Address-space type of the page |
| rsp_entry | output | 32 | Page entry after update |

## Verification
The assertions rely on two things about the inputs. First, the request fields are sampled only on the accepting edge, so an assertion may refer back to the address two cycles before a response. Second, the environment never expects a load issued during a translation to take effect. The stimulus fills every array entry before any translation runs, so no lookup ever reads an unloaded location. Requests are driven away from the clock edge, sometimes held high across consecutive cycles to exercise the every-other-cycle rate. Loads are driven in random cycles, including those that collide with an acceptance or a busy cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    FLT_HOLE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_WPROT   = 2'd2,
    FLT_PRIV    = 2'd3
  } fault_e;

  localparam int ENTRY_W   = 32;
  localparam int OFF_W     = 12;
  localparam int VPG_W     = 6;
  localparam int VPG_LSB   = 12;
  localparam int VSEG_LSB  = 18;
  localparam int BIT_VALID = 31;
  localparam int BIT_WR    = 30;
  localparam int BIT_SUP   = 29;
  localparam int BIT_NC    = 28;
  localparam int SPACE_LSB = 26;
  localparam int BIT_USED  = 25;
  localparam int BIT_MOD   = 24;
endpackage

// File: rtl/xlat_segmap.sv
module xlat_segmap #(
  parameter int IDX_W = 8,
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [GRP_W-1:0] wr_grp,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [GRP_W-1:0] rd_grp
);
  localparam int DEPTH = 1 << IDX_W;

  logic [GRP_W-1:0] map_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) map_q[wr_idx] <= wr_grp;
  end

  assign rd_grp = map_q[rd_idx];
endmodule

// File: rtl/xlat_pagemap.sv
module xlat_pagemap #(
  parameter int IDX_W = 10,
  parameter int DAT_W = 32
) (
  input  logic             clk,
  input  logic             cfg_en,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DAT_W-1:0] cfg_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [DAT_W-1:0] wb_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DAT_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] ent_q [DEPTH];

  // The top never enables both in one cycle; write-back takes precedence.
  always_ff @(posedge clk) begin
    if (wb_en)       ent_q[wb_idx]  <= wb_data;
    else if (cfg_en) ent_q[cfg_idx] <= cfg_data;
  end

  assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/xlat_check.sv
module xlat_check
  import xlat_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic               hole,
  input  logic               is_wr,
  input  logic               is_user,
  output logic               fault,
  output fault_e             code,
  output logic [ENTRY_W-1:0] upd_entry
);
  always_comb begin
    fault = 1'b1;
    code  = FLT_HOLE;
    if (hole) begin
      code = FLT_HOLE;
    end else if (!entry[BIT_VALID]) begin
      code = FLT_INVALID;
    end else if (is_wr && !entry[BIT_WR]) begin
      code = FLT_WPROT;
    end else if (is_user && entry[BIT_SUP]) begin
      code = FLT_PRIV;
    end else begin
      fault = 1'b0;
      code  = FLT_HOLE;
    end
  end

  always_comb begin
    upd_entry = entry;
    if (!fault) begin
      upd_entry[BIT_USED] = 1'b1;
      if (is_wr) upd_entry[BIT_MOD] = 1'b1;
    end
  end
endmodule

// File: rtl/xlat_segpage.sv
module xlat_segpage
  import xlat_pkg::*;
#(
  parameter int CTX_W   = 3,
  parameter int VSEG_W  = 5,
  parameter int GRP_W   = 4,
  parameter int FRAME_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [31:0]               req_va,
  input  logic [CTX_W-1:0]          req_ctx,
  input  logic                      req_write,
  input  logic                      req_user,
  input  logic                      seg_wr_en,
  input  logic [CTX_W+VSEG_W-1:0]   seg_wr_idx,
  input  logic [GRP_W-1:0]          seg_wr_grp,
  input  logic                      pte_wr_en,
  input  logic [GRP_W+VPG_W-1:0]    pte_wr_idx,
  input  logic [31:0]               pte_wr_data,
  output logic                      rsp_valid,
  output logic                      rsp_fault,
  output logic [1:0]                rsp_code,
  output logic [FRAME_W+OFF_W-1:0]  rsp_paddr,
  output logic                      rsp_nc,
  output logic [1:0]                rsp_space,
  output logic [31:0]               rsp_entry
);
  localparam int SIDX_W = CTX_W + VSEG_W;
  localparam int PIDX_W = GRP_W + VPG_W;
  localparam int PA_W   = FRAME_W + OFF_W;

  logic               busy_q;
  logic               accept;
  logic               cfg_open;
  logic [SIDX_W-1:0]  seg_rd_idx;
  logic [GRP_W-1:0]   seg_rd_grp;
  logic [GRP_W-1:0]   grp_q;
  logic [VPG_W-1:0]   vpg_q;
  logic [OFF_W-1:0]   off_q;
  logic               wr_q;
  logic               user_q;
  logic               hole_q;
  logic               va_hole;
  logic [PIDX_W-1:0]  pte_idx;
  logic [ENTRY_W-1:0] pte_rd;
  logic               chk_fault;
  fault_e             chk_code;
  logic [ENTRY_W-1:0] chk_upd;
  logic               wb_en;

  assign req_ready  = ~busy_q;
  assign accept     = req_valid & ~busy_q;
  // Loads only land when the block is idle and no request is being taken.
  assign cfg_open   = ~busy_q & ~req_valid;
  assign va_hole    = (req_va[31:29] != 3'b000) && (req_va[31:29] != 3'b111);
  assign seg_rd_idx = {req_ctx, req_va[VSEG_LSB +: VSEG_W]};
  assign pte_idx    = {grp_q, vpg_q};
  assign wb_en      = busy_q & ~chk_fault;

  xlat_segmap #(.IDX_W(SIDX_W), .GRP_W(GRP_W)) u_segmap (
    .clk    (clk),
    .wr_en  (seg_wr_en & cfg_open),
    .wr_idx (seg_wr_idx),
    .wr_grp (seg_wr_grp),
    .rd_idx (seg_rd_idx),
    .rd_grp (seg_rd_grp)
  );

  xlat_pagemap #(.IDX_W(PIDX_W), .DAT_W(ENTRY_W)) u_pagemap (
    .clk      (clk),
    .cfg_en   (pte_wr_en & cfg_open),
    .cfg_idx  (pte_wr_idx),
    .cfg_data (pte_wr_data),
    .wb_en    (wb_en),
    .wb_idx   (pte_idx),
    .wb_data  (chk_upd),
    .rd_idx   (pte_idx),
    .rd_data  (pte_rd)
  );

  xlat_check u_check (
    .entry     (pte_rd),
    .hole      (hole_q),
    .is_wr     (wr_q),
    .is_user   (user_q),
    .fault     (chk_fault),
    .code      (chk_code),
    .upd_entry (chk_upd)
  );

  // Stage 1: segment-map lookup and request capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      grp_q  <= '0;
      vpg_q  <= '0;
      off_q  <= '0;
      wr_q   <= 1'b0;
      user_q <= 1'b0;
      hole_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      grp_q  <= seg_rd_grp;
      vpg_q  <= req_va[VPG_LSB +: VPG_W];
      off_q  <= req_va[OFF_W-1:0];
      wr_q   <= req_write;
      user_q <= req_user;
      hole_q <= va_hole;
    end else begin
      busy_q <= 1'b0;
    end
  end

  // Stage 2: page entry check, write-back and result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= '0;
      rsp_paddr <= '0;
      rsp_nc    <= 1'b0;
      rsp_space <= '0;
      rsp_entry <= '0;
    end else begin
      rsp_valid <= busy_q;
      if (busy_q) begin
        rsp_fault <= chk_fault;
        rsp_code  <= chk_code;
        rsp_entry <= hole_q ? '0 : chk_upd;
        if (chk_fault) begin
          rsp_paddr <= '0;
          rsp_nc    <= 1'b0;
          rsp_space <= '0;
        end else begin
          rsp_paddr <= PA_W'({pte_rd[FRAME_W-1:0], off_q});
          rsp_nc    <= pte_rd[BIT_NC];
          rsp_space <= pte_rd[SPACE_LSB +: 2];
        end
      end
    end
  end
endmodule

// File: rtl/xlat_sva.sv
module xlat_sva #(
  parameter int PA_W = 28
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [31:0]     req_va,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [1:0]      rsp_code,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [31:0]     rsp_entry
);
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 rsp_valid); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_HOLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ($past(req_va[31:29], 2) != 3'b000) && ($past(req_va[31:29], 2) != 3'b111))
      |-> (rsp_fault && rsp_code == 2'd0 && rsp_entry == 32'd0)); // R1

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_paddr == '0); // R4

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[11:0] == $past(req_va[11:0], 2)); // R3

  AST_USED_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_entry[25] && rsp_entry[31] && rsp_code == 2'd0)); // R8
endmodule

bind xlat_segpage xlat_sva #(.PA_W(FRAME_W + 12)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_va    (req_va),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_code  (rsp_code),
  .rsp_paddr (rsp_paddr),
  .rsp_entry (rsp_entry)
);

// File: tb/tb_xlat_segpage.sv
module tb_xlat_segpage;
  localparam int CLK_PERIOD = 10;
  localparam int CTX_W   = 3;
  localparam int VSEG_W  = 5;
  localparam int GRP_W   = 4;
  localparam int FRAME_W = 16;
  localparam int SIDX_W  = CTX_W + VSEG_W;
  localparam int PIDX_W  = GRP_W + 6;
  localparam int PA_W    = FRAME_W + 12;
  localparam int NSEG    = 1 << SIDX_W;
  localparam int NPTE    = 1 << PIDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic [CTX_W-1:0] req_ctx = '0;
  logic req_write = 1'b0;
  logic req_user = 1'b0;
  logic seg_wr_en = 1'b0;
  logic [SIDX_W-1:0] seg_wr_idx = '0;
  logic [GRP_W-1:0] seg_wr_grp = '0;
  logic pte_wr_en = 1'b0;
  logic [PIDX_W-1:0] pte_wr_idx = '0;
  logic [31:0] pte_wr_data = '0;
  logic rsp_valid, rsp_fault, rsp_nc;
  logic [1:0] rsp_code, rsp_space;
  logic [PA_W-1:0] rsp_paddr;
  logic [31:0] rsp_entry;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_segpage #(.CTX_W(CTX_W), .VSEG_W(VSEG_W), .GRP_W(GRP_W), .FRAME_W(FRAME_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_ctx(req_ctx), .req_write(req_write), .req_user(req_user),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_grp(seg_wr_grp),
    .pte_wr_en(pte_wr_en), .pte_wr_idx(pte_wr_idx), .pte_wr_data(pte_wr_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .rsp_nc(rsp_nc), .rsp_space(rsp_space), .rsp_entry(rsp_entry)
  );

  int errors = 0;
  int checks = 0;
  string cur = "R12";

  // Behavioural reference model
  int unsigned seg_m [NSEG];
  logic [31:0] pte_m [NPTE];
  bit m_busy = 0;
  logic [31:0] p_va;
  int unsigned p_ctx;
  bit p_wr, p_user;
  bit e_valid = 0, e_fault = 0, e_nc = 0;
  int unsigned e_code = 0, e_space = 0;
  logic [31:0] e_paddr = 0, e_entry = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (m_busy) begin
      int unsigned top, sidx, pidx, g;
      logic [31:0] e;
      m_busy = 0;
      e_valid = 1;
      top = p_va[31:29];
      e_nc = 0; e_space = 0; e_paddr = 0;
      if (top != 0 && top != 7) begin
        e_fault = 1; e_code = 0; e_entry = 0;
      end else begin
        sidx = p_ctx * (1 << VSEG_W) + ((p_va >> 18) % (1 << VSEG_W));
        g = seg_m[sidx];
        pidx = g * 64 + ((p_va >> 12) % 64);
        e = pte_m[pidx];
        if (!e[31]) begin e_fault = 1; e_code = 1; e_entry = e; end
        else if (p_wr && !e[30]) begin e_fault = 1; e_code = 2; e_entry = e; end
        else if (p_user && e[29]) begin e_fault = 1; e_code = 3; e_entry = e; end
        else begin
          e_fault = 0; e_code = 0;
          e = e | 32'h0200_0000 | (p_wr ? 32'h0100_0000 : 32'h0);
          pte_m[pidx] = e;
          e_entry = e;
          e_paddr = ((e % 32'h10000) << 12) | (p_va % 4096);
          e_nc = e[28];
          e_space = e[27:26];
        end
      end
    end else begin
      e_valid = 0;
      if (req_valid) begin
        m_busy = 1;
        p_va = req_va; p_ctx = req_ctx; p_wr = req_write; p_user = req_user;
      end else begin
        if (seg_wr_en) seg_m[seg_wr_idx] = seg_wr_grp;
        if (pte_wr_en) pte_m[pte_wr_idx] = pte_wr_data;
      end
    end
  endtask

  task automatic compare();
    chk("R10", "req_ready", req_ready, !m_busy);
    chk("R10", "rsp_valid", rsp_valid, e_valid);
    if (e_valid && rsp_valid) begin
      chk(cur, "rsp_fault", rsp_fault, e_fault);
      chk(cur, "rsp_code", rsp_code, e_code);
      chk(cur, "rsp_paddr", rsp_paddr, e_paddr);
      chk(cur, "rsp_nc", rsp_nc, e_nc);
      chk(cur, "rsp_space", rsp_space, e_space);
      chk(cur, "rsp_entry", rsp_entry, e_entry);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic set_seg(int unsigned idx, int unsigned g);
    seg_wr_en = 1; seg_wr_idx = SIDX_W'(idx); seg_wr_grp = GRP_W'(g);
    cyc();
    seg_wr_en = 0;
  endtask

  task automatic set_pte(int unsigned idx, logic [31:0] d);
    pte_wr_en = 1; pte_wr_idx = PIDX_W'(idx); pte_wr_data = d;
    cyc();
    pte_wr_en = 0;
  endtask

  function automatic logic [31:0] mk_va(int unsigned top, int unsigned vseg, int unsigned vpg, int unsigned off);
    return (32'(top) << 29) | (32'(vseg % (1 << VSEG_W)) << 18) | (32'(vpg % 64) << 12) | 32'(off % 4096);
  endfunction

  task automatic xl(logic [31:0] va, int unsigned ctx, bit wr, bit user);
    req_valid = 1; req_va = va; req_ctx = CTX_W'(ctx); req_write = wr; req_user = user;
    cyc();
    req_valid = 0;
    cyc();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "req_ready in reset", req_ready, 1);
    chk("R12", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "req_ready after reset", req_ready, 1);
    chk("R12", "rsp_valid after reset", rsp_valid, 0);

    // Fill both arrays completely
    cur = "R3";
    for (int i = 0; i < NPTE; i++) begin
      logic [31:0] v;
      v = 32'(i) * 32'h9E37_79B1;
      v = v ^ (v >> 13);
      v[24] = 0; v[25] = 0;
      pte_wr_en = 1; pte_wr_idx = PIDX_W'(i); pte_wr_data = v;
      seg_wr_en = (i < NSEG);
      seg_wr_idx = SIDX_W'(i); seg_wr_grp = GRP_W'((i * 5 + 3) % (1 << GRP_W));
      cyc();
    end
    pte_wr_en = 0; seg_wr_en = 0;

    // R2: context selects different map entries
    cur = "R2";
    set_seg(1 * 32 + 3, 2);
    set_seg(2 * 32 + 3, 5);
    set_pte(2 * 64 + 4, 32'h8000_1111);
    set_pte(5 * 64 + 4, 32'h8000_2222);
    xl(mk_va(0, 3, 4, 12'h5A5), 1, 0, 0);
    xl(mk_va(0, 3, 4, 12'h5A5), 2, 0, 0);
    // R3: upper segment alias 111, different offsets
    cur = "R3";
    xl(mk_va(7, 3, 4, 12'hFFF), 1, 0, 1);
    xl(mk_va(0, 3, 4, 12'h000), 2, 1, 0);

    // R1: holes
    cur = "R1";
    xl(32'h4000_0000, 0, 0, 0);
    xl(32'hA000_1234, 3, 1, 1);
    xl(32'hC000_0000, 0, 0, 0);

    // R4/R5/R6/R7 on a dedicated group
    set_seg(0 * 32 + 9, 7);
    cur = "R4";
    set_pte(7 * 64 + 1, 32'h7FFF_ABCD);
    xl(mk_va(0, 9, 1, 7), 0, 0, 0);
    cur = "R5";
    set_pte(7 * 64 + 2, 32'h8000_0042);
    xl(mk_va(0, 9, 2, 7), 0, 1, 0);
    cur = "R6";
    set_pte(7 * 64 + 3, 32'hE000_0043);
    xl(mk_va(0, 9, 3, 7), 0, 0, 1);
    cur = "R7";
    set_pte(7 * 64 + 5, 32'h2000_0044);
    xl(mk_va(0, 9, 5, 1), 0, 1, 1);
    set_pte(7 * 64 + 6, 32'hA000_0045);
    xl(mk_va(0, 9, 6, 1), 0, 1, 1);
    xl(mk_va(2, 9, 6, 1), 0, 1, 1);

    // R8: used/modified written back, seen by a later read
    cur = "R8";
    set_pte(7 * 64 + 8, 32'hC000_0777);
    xl(mk_va(0, 9, 8, 3), 0, 1, 0);
    xl(mk_va(0, 9, 8, 3), 0, 0, 1);
    set_pte(7 * 64 + 9, 32'h8000_0778);
    xl(mk_va(0, 9, 9, 3), 0, 0, 0);

    // R9: non-cacheable and space type
    cur = "R9";
    set_pte(7 * 64 + 10, 32'h9C00_0ABC);
    xl(mk_va(0, 9, 10, 2), 0, 0, 0);
    set_pte(7 * 64 + 11, 32'h8400_0ABD);
    xl(mk_va(0, 9, 11, 2), 0, 0, 0);

    // R11: load during busy cycle and during acceptance is dropped
    cur = "R11";
    set_pte(7 * 64 + 12, 32'h8000_1234);
    req_valid = 1; req_va = mk_va(0, 9, 12, 0); req_ctx = 0; req_write = 0; req_user = 0;
    pte_wr_en = 1; pte_wr_idx = PIDX_W'(7 * 64 + 12); pte_wr_data = 32'h0;
    cyc();
    req_valid = 0;
    cyc();
    pte_wr_en = 0;
    seg_wr_en = 1; seg_wr_idx = SIDX_W'(9); seg_wr_grp = 0;
    req_valid = 1;
    cyc();
    req_valid = 0; seg_wr_en = 0;
    cyc();
    xl(mk_va(0, 9, 12, 0), 0, 0, 0);

    // R10: held request, back-to-back at half rate
    cur = "R10";
    req_valid = 1;
    for (int i = 0; i < 12; i++) begin
      req_va = mk_va((i % 3 == 2) ? 7 : 0, i, i * 3, i * 77);
      req_ctx = CTX_W'(i); req_write = i[0]; req_user = i[1];
      cyc();
    end
    req_valid = 0;
    cyc();

    // Mixed random traffic
    cur = "R8";
    for (int i = 0; i < 600; i++) begin
      int unsigned r, t;
      r = $urandom;
      t = r % 8;
      req_valid = (r[4:3] != 0);
      req_va = mk_va((t < 3) ? 0 : (t < 6) ? 7 : t - 5, $urandom, $urandom, $urandom);
      req_ctx = CTX_W'($urandom); req_write = r[8]; req_user = r[9];
      seg_wr_en = (r[13:10] == 0); seg_wr_idx = SIDX_W'($urandom); seg_wr_grp = GRP_W'($urandom);
      pte_wr_en = (r[17:14] == 0); pte_wr_idx = PIDX_W'($urandom); pte_wr_data = $urandom;
      cyc();
    end
    req_valid = 0; seg_wr_en = 0; pte_wr_en = 0;
    cyc();
    cyc();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule